// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block sits on the device side of a 16-bit flash bus. It watches the write cycles that reach the device and recognises the multi-cycle unlock sequences that guard every change to the array. A recognised sequence produces a one-cycle operation pulse. The pulse carries the operation kind, the target bank, the target address and, for a program, the data word. A sequence can also switch the device into or out of an identification mode or an erase-verify mode.

Each write cycle is one clock with `wr_en` high. The command cycles compare only the low 15 address bits and the low data byte. The bank is taken from bits 19:18 of the last cycle of a sequence. A write that does not fit the sequence discards the partial sequence. A write-protect input guards the top 128K words of the address space against program, sector erase and block erase. While the array is busy, all writes are ignored.

While identification mode is active, a separate read address selects the maker code or the bank's device code. The array and the timing of its operations are handled elsewhere.

Top module: `flash_unlock_decoder`

## Requirements
- R1: A command cycle matches on address bits 14:0 and data bits 7:0 only. Address bits 17:15 and data bits 15:8 of a command cycle have no effect. Every sequence opens with data AAh at address 5555h, followed by data 55h at address 2AAAh.
- R2: A third cycle of A0h at 5555h arms a program. The next write then makes `op_valid` high for exactly the clock after that write, with `op_kind`=1 and `op_addr`/`op_data` equal to that write's address and full 16-bit data.
- R3: A third cycle of 80h at 5555h, then AAh at 5555h and 55h at 2AAAh, leads to a sixth cycle that selects the erase. 10h at 5555h gives chip erase: kind 4, `op_addr` = final bits 19:18 followed by zeros. 30h at any address gives sector erase: kind 2, address bits 9:0 cleared. 50h at any address gives block erase: kind 3, address bits 14:0 cleared. `op_data` is 0 for every erase.
- R4: `op_bank` is 1 (bank 1) when bits 19:18 of the final cycle are both 1, and 0 (bank 2) for any other combination.
- R5: A write whose address or data does not fit the next step of a sequence ends that sequence with no effect. That write is itself consumed, and the next write is treated as a first cycle.
- R6: With `wp_n` low at the final cycle, a program, sector erase or block erase whose target has bits 19:17 = 111 is dropped. A chip erase under the same condition is issued with `op_guard` high for the pulse; otherwise `op_guard` is 0.
- R7: A third cycle of 90h at 5555h sets `id_mode`. While it is set, `id_data` returns 0062h when `rd_addr` bits 17:0 are 0. When those bits are 1, it returns 257Eh if `rd_addr` bits 19:18 are 11 and 257Dh otherwise. In every other case `id_data` is 0.
- R8: While `id_mode` is set, the only command accepted at the third cycle is F0h. A0h, 80h and 90h there abort the sequence, and no operation is issued.
- R9: A sixth cycle of B0h at 5555h sets `ev_mode`. A third cycle of F0h at 5555h clears both `id_mode` and `ev_mode`.
- R10: While `busy` is high, a write has no effect at all. The sequence in progress, both modes and the outputs stay as they were.
- R11: Synchronous `rst` high returns the decoder to expect a first cycle and clears `id_mode`, `ev_mode`, `op_valid` and the held operation fields.
- R12: Clocks with `wr_en` low leave a partial sequence intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | A write cycle is present this clock |
| wr_addr | input | 20 | Write word address |
| wr_data | input | 16 | Write data |
| wp_n | input | 1 | Write protect of the top 128K words, active low |
| busy | input | 1 | A program or erase is in progress |
| rd_addr | input | 20 | Read address for identification codes |
| op_valid | output | 1 | One-clock operation pulse |
| op_kind | output | 3 | 1 program, 2 sector, 3 block, 4 chip erase |
| op_bank | output | 1 | 1 = bank 1, 0 = bank 2 |
| op_addr | output | 20 | Target address of the operation |
| op_data | output | 16 | Program data word |
| op_guard | output | 1 | Chip erase must spare the protected range |
| id_mode | output | 1 | Identification mode active |
| ev_mode | output | 1 | Erase-verify mode active |
| id_data | output | 16 | Identification code for rd_addr |

## Verification
Every command is driven as back-to-back writes and again with idle clocks inside the sequence. This separates a decoder that tracks cycles from one that counts clocks. Command cycles carry set bits in address bits 17:15 and data bits 15:8, and final cycles target both banks. Wrong data or a wrong address at various steps, protected and unprotected targets under both write-protect levels, writes landing while busy, and commands issued inside identification mode each tell apart a different abort or ignore path. A behavioural model that holds the accepted writes in a queue predicts every output on every clock.

// File: rtl/flash_unlock_decoder.sv
module flash_unlock_decoder #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CAW = 15,
  parameter int SECT_BITS = 10,
  parameter int BLK_BITS = 15,
  parameter int PROT_BITS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wp_n,
  input  logic          busy,
  input  logic [AW-1:0] rd_addr,
  output logic          op_valid,
  output logic [2:0]    op_kind,
  output logic          op_bank,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          op_guard,
  output logic          id_mode,
  output logic          ev_mode,
  output logic [DW-1:0] id_data
);
  localparam logic [CAW-1:0] KEY_A = CAW'(16'h5555);
  localparam logic [CAW-1:0] KEY_B = CAW'(16'h2AAA);
  localparam logic [2:0] K_PGM = 3'd1, K_SEC = 3'd2, K_BLK = 3'd3, K_CHIP = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5} st_t;
  st_t st;

  logic [7:0] dlo;
  logic at_a, at_b, in_prot, blocked, take;
  assign dlo     = wr_data[7:0];
  assign at_a    = wr_addr[CAW-1:0] == KEY_A;
  assign at_b    = wr_addr[CAW-1:0] == KEY_B;
  assign in_prot = &wr_addr[AW-1:AW-PROT_BITS];
  assign blocked = !wp_n && in_prot;
  assign take    = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      id_mode <= 1'b0;
      ev_mode <= 1'b0;
      op_valid <= 1'b0;
      op_kind <= '0;
      op_bank <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      op_guard <= 1'b0;
    end else begin
      op_valid <= 1'b0;
      op_guard <= 1'b0;
      if (take) begin
        st <= S_IDLE;
        case (st)
          S_IDLE: if (at_a && dlo == 8'hAA) st <= S_U1;
          S_U1:   if (at_b && dlo == 8'h55) st <= S_U2;
          S_U2: if (at_a) begin
            case (dlo)
              8'hA0: if (!id_mode) st <= S_PGM;
              8'h80: if (!id_mode) st <= S_E3;
              8'h90: id_mode <= 1'b1;
              8'hF0: begin id_mode <= 1'b0; ev_mode <= 1'b0; end
              default: ;
            endcase
          end
          S_PGM: if (!blocked) begin
            op_valid <= 1'b1;
            op_kind <= K_PGM;
            op_bank <= &wr_addr[AW-1:AW-2];
            op_addr <= wr_addr;
            op_data <= wr_data;
          end
          S_E3: if (at_a && dlo == 8'hAA) st <= S_E4;
          S_E4: if (at_b && dlo == 8'h55) st <= S_E5;
          S_E5: begin
            if (dlo == 8'hB0 && at_a) ev_mode <= 1'b1;
            if ((dlo == 8'h10 && at_a) || ((dlo == 8'h30 || dlo == 8'h50) && !blocked)) begin
              op_valid <= 1'b1;
              op_bank <= &wr_addr[AW-1:AW-2];
              op_data <= '0;
              if (dlo == 8'h10) begin
                op_kind <= K_CHIP;
                op_addr <= {wr_addr[AW-1:AW-2], {(AW-2){1'b0}}};
                op_guard <= !wp_n;
              end else if (dlo == 8'h30) begin
                op_kind <= K_SEC;
                op_addr <= {wr_addr[AW-1:SECT_BITS], {SECT_BITS{1'b0}}};
              end else begin
                op_kind <= K_BLK;
                op_addr <= {wr_addr[AW-1:BLK_BITS], {BLK_BITS{1'b0}}};
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign id_data = !id_mode ? '0 :
                   (rd_addr[AW-3:0] == '0) ? DW'(16'h0062) :
                   (rd_addr[AW-3:0] == (AW-2)'(1)) ? (&rd_addr[AW-1:AW-2] ? DW'(16'h257E) : DW'(16'h257D)) :
                   '0;

  assert_busy_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> !op_valid && $stable(id_mode) && $stable(ev_mode));

  assert_protect_R6: assert property (@(posedge clk) disable iff (rst)
    op_valid && !$past(wp_n) && op_kind != K_CHIP |-> op_addr[AW-1:AW-PROT_BITS] != '1);

  assert_op_from_write_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> $past(wr_en) && !$past(busy));

  assert_no_op_in_id_R8: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> !$past(id_mode));

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> !id_mode && !ev_mode && !op_valid);
endmodule

// File: tb/test_flash_unlock_decoder.sv
module test_flash_unlock_decoder;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, wp_n = 1'b1, busy = 1'b0;
  logic [19:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic op_valid, op_bank, op_guard, id_mode, ev_mode;
  logic [2:0] op_kind;
  logic [19:0] op_addr;
  logic [15:0] op_data, id_data;

  flash_unlock_decoder i_flash_unlock_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wp_n(wp_n), .busy(busy), .rd_addr(rd_addr), .op_valid(op_valid), .op_kind(op_kind),
    .op_bank(op_bank), .op_addr(op_addr), .op_data(op_data), .op_guard(op_guard),
    .id_mode(id_mode), .ev_mode(ev_mode), .id_data(id_data));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  string scen = "R11 reset";
  logic s_rst = 1'b1, s_wp = 1'b1, s_busy = 1'b0;
  logic [19:0] s_rd = '0;

  logic [19:0] qa[$];
  logic [15:0] qd[$];
  logic e_v, e_bank, e_guard, e_id, e_ev;
  logic [2:0] e_kind;
  logic [19:0] e_addr;
  logic [15:0] e_data, e_idd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
    end
  endtask

  task automatic emit(input int k, input logic [19:0] a, input logic [15:0] d, input logic g);
    e_v = 1; e_kind = 3'(k); e_addr = a; e_data = d; e_guard = g;
    e_bank = (a[19:18] == 2'b11);
  endtask

  function automatic bit hit(input int i, input logic [14:0] a, input logic [7:0] d);
    return qa[i][14:0] == a && qd[i][7:0] == d;
  endfunction

  task automatic model_write(input logic [19:0] a, input logic [15:0] d, input logic wp);
    bit keep;
    logic prot;
    prot = !wp && a[19:17] == 3'b111;
    qa.push_back(a); qd.push_back(d);
    keep = 0;
    case (qa.size())
      1: keep = hit(0, 15'h5555, 8'hAA);
      2: keep = hit(1, 15'h2AAA, 8'h55);
      3: if (qa[2][14:0] == 15'h5555) begin
        if (d[7:0] == 8'h90) e_id = 1;
        else if (d[7:0] == 8'hF0) begin e_id = 0; e_ev = 0; end
        else if ((d[7:0] == 8'hA0 || d[7:0] == 8'h80) && !e_id) keep = 1;
      end
      4: if (qd[2][7:0] == 8'hA0) begin
        if (!prot) emit(1, a, d, 0);
      end else keep = hit(3, 15'h5555, 8'hAA);
      5: keep = hit(4, 15'h2AAA, 8'h55);
      6: begin
        if (d[7:0] == 8'h10 && a[14:0] == 15'h5555) emit(4, {a[19:18], 18'h0}, 0, !wp);
        else if (d[7:0] == 8'hB0 && a[14:0] == 15'h5555) e_ev = 1;
        else if (d[7:0] == 8'h30 && !prot) emit(2, {a[19:10], 10'h0}, 0, 0);
        else if (d[7:0] == 8'h50 && !prot) emit(3, {a[19:15], 15'h0}, 0, 0);
      end
      default: ;
    endcase
    if (!keep) begin qa.delete(); qd.delete(); end
  endtask

  task automatic cyc(input logic w, input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    chk("R2 op_valid", op_valid, e_v);
    if (e_v) begin
      chk("R3 op_kind", op_kind, e_kind);
      chk("R3 op_addr", op_addr, e_addr);
      chk("R4 op_bank", op_bank, e_bank);
      chk("R2 op_data", op_data, e_data);
    end
    chk("R6 op_guard", op_guard, e_guard);
    chk("R7 id_mode", id_mode, e_id);
    chk("R9 ev_mode", ev_mode, e_ev);
    chk("R7 id_data", id_data, e_idd);
    rst = s_rst; wr_en = w; wr_addr = a; wr_data = d; wp_n = s_wp; busy = s_busy; rd_addr = s_rd;
    e_v = 0; e_guard = 0;
    if (s_rst) begin
      qa.delete(); qd.delete();
      e_id = 0; e_ev = 0; e_kind = 0; e_addr = 0; e_data = 0; e_bank = 0;
    end else if (w && !s_busy) model_write(a, d, s_wp);
    if (!e_id) e_idd = 0;
    else if (s_rd[17:0] == 0) e_idd = 16'h0062;
    else if (s_rd[17:0] == 1) e_idd = (s_rd[19:18] == 2'b11) ? 16'h257E : 16'h257D;
    else e_idd = 0;
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d); cyc(1, a, d); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(0, 0, 0); endtask
  task automatic cmd3(input logic [19:0] a3, input logic [15:0] d3);
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(a3, d3);
  endtask
  task automatic cmd6(input logic [19:0] a6, input logic [15:0] d6);
    cmd3(20'h05555, 16'h0080); wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(a6, d6);
  endtask

  initial begin
    e_v = 0; e_bank = 0; e_guard = 0; e_id = 0; e_ev = 0; e_kind = 0; e_addr = 0; e_data = 0; e_idd = 0;
    idle(3);
    s_rst = 0; idle(2);
    scen = "R2 program bank 2";  cmd3(20'h05555, 16'h00A0); wr(20'h01234, 16'hBEEF); idle(2);
    scen = "R12 idle gaps";      wr(20'h05555, 16'h00AA); idle(3); wr(20'h02AAA, 16'h0055); idle(2);
                                 wr(20'h05555, 16'h00A0); idle(4); wr(20'hC1000, 16'h1357); idle(2);
    scen = "R1 dont-care bits";  wr(20'h3D555, 16'h12AA); wr(20'hBAAAA, 16'hFF55); wr(20'h7D555, 16'h34A0);
                                 wr(20'h0ABCD, 16'h00C3); idle(2);
    scen = "R3 sector bank 2";   cmd6(20'h56789, 16'h0030); idle(2);
    scen = "R3 block bank 1";    cmd6(20'hD9ABC, 16'h0050); idle(2);
    scen = "R3 chip bank 2";     cmd6(20'h45555, 16'h0010); idle(2);
    s_wp = 0;
    scen = "R6 chip guarded";    cmd6(20'hC5555, 16'h0010); idle(2);
    scen = "R6 program blocked"; cmd3(20'h05555, 16'h00A0); wr(20'hE0010, 16'h4444); idle(2);
    scen = "R6 sector blocked";  cmd6(20'hFFC00, 16'h0030); idle(2);
    scen = "R6 block blocked";   cmd6(20'hE8000, 16'h0050); idle(2);
    scen = "R6 unprotected ok";  cmd3(20'h05555, 16'h00A0); wr(20'hDFFFF, 16'h5555); idle(2);
    s_wp = 1;
    scen = "R6 wp high ok";      cmd3(20'h05555, 16'h00A0); wr(20'hE0010, 16'h4444); idle(2);
    scen = "R5 bad data step2";  wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0056); wr(20'h05555, 16'h00A0);
                                 wr(20'h00100, 16'h0101); idle(2);
    scen = "R5 bad addr step5";  cmd3(20'h05555, 16'h0080); wr(20'h05555, 16'h00AA); wr(20'h02AAB, 16'h0055);
                                 wr(20'h05555, 16'h0010); idle(2);
    scen = "R5 bad cmd then ok"; cmd3(20'h05555, 16'h0077); cmd3(20'h05555, 16'h00A0); wr(20'h00200, 16'h0202); idle(2);
    scen = "R7 id entry";        cmd3(20'hC5555, 16'h0090); idle(1);
    s_rd = 20'hC0000; idle(2); s_rd = 20'hC0001; idle(2); s_rd = 20'h40001; idle(2);
    s_rd = 20'h00000; idle(1); s_rd = 20'h00002; idle(2);
    scen = "R8 no program in id"; cmd3(20'h05555, 16'h00A0); wr(20'h00300, 16'h0303); idle(2);
    scen = "R8 no erase in id";  cmd6(20'h05555, 16'h0010); idle(2);
    scen = "R9 id exit";         cmd3(20'h85555, 16'h00F0); idle(2);
    scen = "R9 ev entry";        cmd6(20'h05555, 16'h00B0); idle(2);
    scen = "R3 sector in ev";    cmd6(20'h00400, 16'h0030); idle(2);
    scen = "R9 ev exit";         cmd3(20'h05555, 16'h00F0); idle(2);
    scen = "R10 busy mid seq";   wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055);
    s_busy = 1; wr(20'h09999, 16'h0099); s_busy = 0;
                                 wr(20'h05555, 16'h00A0); wr(20'h00500, 16'h0505); idle(2);
    scen = "R10 busy final";     cmd3(20'h05555, 16'h00A0); s_busy = 1; wr(20'h00600, 16'h0606);
    s_busy = 0; idle(2);
    scen = "R10 busy id entry";  wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); s_busy = 1;
    wr(20'h05555, 16'h0090); s_busy = 0; idle(2);
    scen = "R11 reset mid seq";  cmd3(20'h05555, 16'h0090); s_rd = 20'h00001; idle(1);
                                 wr(20'h05555, 16'h00AA); s_rst = 1; idle(1); s_rst = 0;
                                 wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h00A0); wr(20'h00700, 16'h0707); idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", scen, cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule